// File: doc/BRIEF.md
# Converter Result Serial Readout Port

This block sits on the device side of a serial link and hands 20-bit conversion results to an external host. A free-running timer in the master-clock domain marks a fixed update point. At each update point the current result from the converter core is captured into a holding register and an active-low ready flag is raised, which tells the host that a fresh word is waiting.

The host starts a read by pulling an active-low select line and then supplies its own serial clock. The block answers with the word, most significant bit first, and moves to the next bit after every falling edge of that clock. Select and serial clock arrive asynchronously. Each passes through a two-flop synchroniser, and its edges are found in the master-clock domain. Select is not accepted in a short guard window just before each update. If the host deselects partway through a frame, the block releases the line cleanly. The data pin is driven through an output-enable that a pad-level tri-state buffer uses.

Top module: `result_serial_port`

## Requirements
- R1: When `rst_n` is low at a clock edge, `sdata_oe` is 0 and `rdy_n` is 1 after that edge.
- R2: Every UPDATE_PERIOD (default 1024) master-clock cycles, `word_in` is captured and `rdy_n` goes to 0. Two consecutive falls of `rdy_n` are exactly UPDATE_PERIOD cycles apart.
- R3: A falling edge on `cs_n` outside the guard window sets `sdata_oe` to 1 within 4 master-clock cycles, and `sdata_o` then carries bit 19 of the captured word.
- R4: The word leaves MSB first. `sdata_o` holds its bit until a falling edge of `sclk` is seen, and then moves to the next lower bit. A new select restarts from bit 19.
- R5: After the 20th falling `sclk` edge of a frame, `sdata_oe` returns to 0 and `rdy_n` returns to 1 within 5 cycles.
- R6: The word in flight stays fixed if an update falls inside the frame. In that case `rdy_n` stays 0 after the frame, so the newer word is still announced.
- R7: In the last BLOCK_CYCLES (default 4) cycles of each period, `rdy_n` is 1. A select edge recognised in that window is ignored, even if `cs_n` is held low afterwards: `sdata_oe` stays 0 until a later deselect and reselect.
- R8: If `cs_n` rises before bit 0 has been clocked out and `sclk` is low, `sdata_oe` drops within 4 cycles. If `sclk` is high, the current bit is kept on `sdata_o` until the next falling `sclk` edge, and `sdata_oe` drops after that edge.
- R9: An aborted frame does not consume the word: `rdy_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | WORD_W | Result word from the converter core |
| cs_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the data pad (0 = high impedance) |
| rdy_n | output | 1 | Fresh-word flag, active low |

## Verification
The hardest case to reach is a select that lands inside the four-cycle guard window. The bench syncs to the window by watching `rdy_n`. It waits for an update (falling `rdy_n`), makes sure no frame consumes the word, and then waits for the rising `rdy_n` that opens the window. It pulls `cs_n` on the next half cycle, so the synchronised edge reaches the engine while the window is still open. The bench also times a slow read to begin about 880 cycles into a period, so the update falls in the middle of the frame. The two kinds of abort are driven with `sclk` held at each level.

// File: rtl/rsp_pkg.sv
// Shared types for the result serial readout port.
package rsp_pkg;

    // Shift engine state.
    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a select edge
        ST_SHIFT,  // frame in progress
        ST_TAIL,   // aborted while sclk high: finishing the current bit
        ST_WAIT    // full word sent, waiting for deselect
    } rsp_state_e;

endpackage

// File: rtl/rsp_edge_sync.sv
// Two-flop synchroniser for one asynchronous host line, with a falling-edge
// detector in the master-clock domain.
// Assumes: the line is held for at least two master cycles per level.
module rsp_edge_sync #(
    parameter bit IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);

    logic meta_q, sync_q, prev_q;

    // Synchronise the line and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= IDLE_VAL;
            sync_q <= IDLE_VAL;
            prev_q <= IDLE_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign fall  = prev_q & ~sync_q;

endmodule

// File: rtl/rsp_update_timer.sv
// Free-running period counter. Marks the update cycle, the cycle before the
// guard window opens, and the window itself (the last BLOCK cycles).
// Assumes: 0 < BLOCK < PERIOD - 1.
module rsp_update_timer #(
    parameter int PERIOD = 1024,
    parameter int BLOCK  = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic upd,
    output logic win_begin,
    output logic in_win
);

    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(PERIOD - BLOCK);
    localparam logic [CNT_W-1:0] PRE_WIN = CNT_W'(PERIOD - BLOCK - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count master cycles and wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST_C) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign upd       = (cnt_q == LAST_C);
    assign win_begin = (cnt_q == PRE_WIN);
    assign in_win    = (cnt_q >= WIN_LO);

endmodule

// File: rtl/rsp_shift_engine.sv
// Frame engine. It copies the held word into a shift register on an
// accepted select, moves one bit per falling sclk edge, and handles abort
// and completion. It pulses 'consumed' when a whole frame has gone out and
// no update arrived while it was running.
// Assumes: level/fall inputs come from rsp_edge_sync instances.
module rsp_shift_engine
    import rsp_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              in_win,
    input  logic              upd,
    input  logic              cs_level,
    input  logic              cs_fall,
    input  logic              sclk_level,
    input  logic              sclk_fall,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic              consumed,
    output rsp_state_e        state
);

    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [BC_W-1:0]   bcnt_q;
    logic              upd_seen_q;

    // Frame sequencing, shifting and output-enable control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sdata_oe   <= 1'b0;
            shreg_q    <= '0;
            bcnt_q     <= '0;
            upd_seen_q <= 1'b0;
            consumed   <= 1'b0;
        end else begin
            consumed <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cs_fall && !in_win) begin
                        shreg_q    <= hold_word;
                        bcnt_q     <= '0;
                        upd_seen_q <= 1'b0;
                        sdata_oe   <= 1'b1;
                        state      <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (upd) upd_seen_q <= 1'b1;
                    if (cs_level) begin
                        if (sclk_level) begin
                            state <= ST_TAIL;
                        end else begin
                            sdata_oe <= 1'b0;
                            state    <= ST_IDLE;
                        end
                    end else if (sclk_fall) begin
                        if (bcnt_q == LAST_BIT) begin
                            sdata_oe <= 1'b0;
                            consumed <= !(upd_seen_q || upd);
                            state    <= ST_WAIT;
                        end else begin
                            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                            bcnt_q  <= bcnt_q + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (!sclk_level) begin
                        sdata_oe <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (cs_level) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sdata_o = shreg_q[WORD_W-1];

endmodule

// File: rtl/result_serial_port.sv
// Top of the result serial readout port. It captures the converter word
// once per period, drives the active-low ready flag, and connects the
// synchronisers, the timer and the shift engine.
// Assumes: clk is the master clock; cs_n and sclk are asynchronous to it.
module result_serial_port #(
    parameter int WORD_W        = 20,
    parameter int UPDATE_PERIOD = 1024,
    parameter int BLOCK_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic              rdy_n
);

    import rsp_pkg::*;

    logic              upd, win_begin, in_win;
    logic              cs_level, cs_fall, sclk_level, sclk_fall;
    logic              consumed;
    logic [WORD_W-1:0] hold_q;
    rsp_state_e        eng_state;

    rsp_edge_sync #(.IDLE_VAL(1'b1)) i_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .level(cs_level), .fall(cs_fall)
    );

    rsp_edge_sync #(.IDLE_VAL(1'b0)) i_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk), .level(sclk_level), .fall(sclk_fall)
    );

    rsp_update_timer #(.PERIOD(UPDATE_PERIOD), .BLOCK(BLOCK_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .upd(upd), .win_begin(win_begin), .in_win(in_win)
    );

    rsp_shift_engine #(.WORD_W(WORD_W)) i_engine (
        .clk(clk), .rst_n(rst_n), .hold_word(hold_q), .in_win(in_win), .upd(upd),
        .cs_level(cs_level), .cs_fall(cs_fall),
        .sclk_level(sclk_level), .sclk_fall(sclk_fall),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .consumed(consumed),
        .state(eng_state)
    );

    // Capture the converter result at each update point.
    always_ff @(posedge clk) begin
        if (!rst_n)   hold_q <= '0;
        else if (upd) hold_q <= word_in;
    end

    // Ready flag: set low by an update, high by the window or a consumed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rdy_n <= 1'b1;
        else if (upd)                   rdy_n <= 1'b0;
        else if (win_begin || consumed) rdy_n <= 1'b1;
    end

endmodule

// File: rtl/result_serial_port_chk.sv
// Temporal checks for result_serial_port, bound to every instance.
module result_serial_port_chk
    import rsp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdata_o,
    input logic       sdata_oe,
    input logic       rdy_n,
    input logic       upd,
    input logic       in_win,
    input logic       sclk_fall,
    input rsp_state_e state
);

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (!sdata_oe && rdy_n));

    // R2
    update_flags_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !rdy_n);

    // R3
    drive_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> ($past(cs_n, 3) == 1'b0));

    // R4
    data_hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$past(sclk_fall)) |-> $stable(sdata_o));

    // R7
    window_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && state == ST_IDLE) |=> (state != ST_SHIFT));

endmodule

bind result_serial_port result_serial_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .rdy_n(rdy_n), .upd(upd), .in_win(in_win),
    .sclk_fall(sclk_fall), .state(eng_state)
);

// File: tb/test_result_serial_port.sv
// Scoreboard bench: the driver records each captured word in a queue, and
// frame reads take the latest entry as their expectation.
module test_result_serial_port;

    localparam int W = 20;
    localparam int PERIOD = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdata_o, sdata_oe, rdy_n;

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    logic [W-1:0] latched_q[$];

    result_serial_port i_result_serial_port (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .cs_n(cs_n), .sclk(sclk),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .rdy_n(rdy_n)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: present a word and wait for the update that captures it.
    task automatic load_word(input logic [W-1:0] w, output longint when);
        word_in = w;
        @(negedge rdy_n);
        @(negedge clk);
        when = cyc;
        latched_q.push_back(w);
    endtask

    task automatic select_port();
        cs_n = 1'b0;
        ticks(4);
    endtask

    // Clock n bits out, starting at bit index 'first' from the top.
    task automatic shift_bits(input int first, input int n, output logic [W-1:0] got,
                              output int oe_drops);
        got = '0;
        oe_drops = 0;
        for (int i = 0; i < n; i++) begin
            if (!sdata_oe) oe_drops++;
            got[W-1-(first+i)] = sdata_o;
            sclk = 1'b1; ticks(4);
            sclk = 1'b0; ticks(4);
        end
    endtask

    task automatic read_frame(input string req);
        logic [W-1:0] exp, got;
        int drops;
        exp = latched_q[$];
        select_port();
        check(sdata_oe == 1'b1 && sdata_o == exp[W-1], {req, " R3 drive+MSB"},
              {sdata_oe, sdata_o}, {1'b1, exp[W-1]});
        shift_bits(0, W, got, drops);
        check(got == exp && drops == 0, {req, " R4 word MSB first"}, got, exp);
        ticks(1);
        check(sdata_oe == 1'b0, {req, " R5 released"}, sdata_oe, 0);
        cs_n = 1'b1;
        ticks(4);
    endtask

    initial begin
        longint t_a, t_b, t_c, t_d;
        logic [W-1:0] got;
        int drops;

        ticks(5);
        check(sdata_oe == 1'b0 && rdy_n == 1'b1, "R1 reset state", {sdata_oe, rdy_n}, 2'b01);
        rst_n = 1'b1;

        // Full read of the first word, then period spacing.
        load_word(20'hB3C5A, t_a);
        check(rdy_n == 1'b0, "R2 ready after update", rdy_n, 0);
        read_frame("A");
        check(rdy_n == 1'b1, "R5 ready cleared", rdy_n, 1);
        load_word(20'h4A6D1, t_b);
        check(t_b - t_a == PERIOD, "R2 period", 32'(t_b - t_a), PERIOD);

        // Abort with sclk low: release promptly, word not consumed.
        select_port();
        shift_bits(0, 5, got, drops);
        cs_n = 1'b1;
        ticks(4);
        check(sdata_oe == 1'b0, "R8 abort sclk low", sdata_oe, 0);
        check(rdy_n == 1'b0, "R9 ready kept after abort", rdy_n, 0);

        // Abort with sclk high: current bit held until falling edge.
        select_port();
        check(sdata_o == 1'b0, "R4 restart at MSB", sdata_o, 0);
        shift_bits(0, 3, got, drops);
        sclk = 1'b1; ticks(4);
        cs_n = 1'b1; ticks(6);
        check(sdata_oe == 1'b1 && sdata_o == 1'b0, "R8 bit held in tail",
              {sdata_oe, sdata_o}, 2'b10);
        sclk = 1'b0; ticks(4);
        check(sdata_oe == 1'b0, "R8 released after tail", sdata_oe, 0);
        read_frame("B");

        // Select landing in the guard window is ignored.
        load_word(20'hFFFFF, t_c);
        @(posedge rdy_n);
        @(negedge clk);
        cs_n = 1'b0;
        ticks(2);
        check(rdy_n == 1'b1, "R7 ready high in window", rdy_n, 1);
        ticks(40);
        check(sdata_oe == 1'b0, "R7 select in window ignored", sdata_oe, 0);
        cs_n = 1'b1;
        ticks(6);
        read_frame("C");

        // Update falling inside a slow frame.
        load_word(20'h00001, t_d);
        word_in = 20'h5555A;
        ticks(880);
        read_frame("D R6");
        check(rdy_n == 1'b0, "R6 ready kept after straddled frame", rdy_n, 0);
        latched_q.push_back(20'h5555A);
        read_frame("E R6 newer word");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule